// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block sits behind an external dual-modulus prescaler and turns its output into the feedback pulse of a frequency synthesiser loop. It runs on the prescaler output as its clock. Each count cycle lasts M of its clock periods. For the first A of those periods the modulus-control output asks the prescaler to divide by P+1. For the rest it asks for P. The VCO is therefore divided by N = M·P + A overall. A one-period feedback pulse marks the last period of every cycle.

New ratio values arrive on the value inputs together with a single-cycle update strobe. They are held as pending values. The running counters only pick them up at the wrap from the last period of a cycle to the first period of the next. A cycle in progress is never cut short or restarted, so a small retune does not disturb the loop phase. Values outside the legal ranges, or with M not above A, are still accepted, but an error output flags them.

Top module: `swallow_counter`

## Requirements
- R1: While `rst` is high, both the running and the pending ratio load from `a_val`/`m_val`. In the first period after release the block is at the start of a cycle: `mc` is low if A > 0, `fv` is low, and `err` reflects the loaded values.
- R2: A count cycle lasts exactly M clock periods. `fv` is high only in the last of them, for one period.
- R3: `mc` is low (prescaler divides by P+1) for the first A periods of a cycle and high (divides by P) from then until the cycle ends. It falls only at a cycle wrap.
- R4: Over one cycle the prescaler input count is M·P + A.
- R5: With A = 0, `mc` stays high for the whole cycle.
- R6: A strobe on `upd` captures `a_val`/`m_val` as pending values. A strobe in mid-cycle leaves the current cycle's length and `mc` timing unchanged. The pending values govern the next cycle.
- R7: A strobe in the period where `fv` is high takes effect for the cycle that starts at the very next edge.
- R8: `err` goes high one edge after a strobe whose M is below 8 or not greater than A, and low after a strobe with legal values. Between strobes it holds. Flagged values are still used, so M = 5 gives a 5-period cycle.
- R9: The range limits work exactly: A = 127 with M = 1023, and A = 7 with M = 8, each give M·P + A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output, used as the counting clock |
| rst | input | 1 | Synchronous active-high reset |
| upd | input | 1 | One-cycle strobe that captures new ratio values |
| a_val | input | 7 | Swallow count A (0..127) |
| m_val | input | 10 | Main count M (8..1023) |
| mc | output | 1 | Modulus control: 0 selects P+1, 1 selects P |
| fv | output | 1 | Feedback pulse, high in the last period of each cycle |
| err | output | 1 | Pending ratio out of range or M not greater than A |

## Verification
On every cycle the assertions check these things: `fv` never lasts more than one period when the pending ratio is legal, `mc` falls only right after an `fv` period, and `err` follows each strobe's values and otherwise holds. Only the directed scenarios can show that a cycle has exactly M periods with A of them low, that the prescaler total equals M·P + A at the range limits, and that a strobe in mid-cycle changes nothing until the wrap while a strobe on the last period applies at once.

// File: rtl/swallow_pkg.sv
package swallow_pkg;
    localparam int A_W   = 7;
    localparam int M_W   = 10;
    localparam int M_MIN = 8;

    typedef logic [A_W-1:0] a_t;
    typedef logic [M_W-1:0] m_t;

    typedef struct packed {
        a_t a;
        m_t m;
    } ratio_t;

    // Ratio is unusable when the main count is below its floor or not above the swallow count.
    function automatic logic ratio_bad(ratio_t r);
        return (r.m < m_t'(M_MIN)) || (r.m <= m_t'(r.a));
    endfunction
endpackage

// File: rtl/swallow_latch.sv
module swallow_latch
    import swallow_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   upd,
    input  ratio_t in_r,
    output ratio_t next_r,
    output logic   bad
);
    ratio_t pend_q;
    logic   bad_q;

    always_ff @(posedge clk) begin
        if (rst || upd) begin
            pend_q <= in_r;
            bad_q  <= ratio_bad(in_r);
        end
    end

    // A strobe on the wrap edge is applied directly.
    assign next_r = upd ? in_r : pend_q;
    assign bad    = bad_q;
endmodule

// File: rtl/swallow_acnt.sv
module swallow_acnt #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         mc
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign mc = (cnt_q == '0);
endmodule

// File: rtl/swallow_mcnt.sv
module swallow_mcnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] load_val,
    output logic         tc
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || tc) begin
            cnt_q <= load_val - 1'b1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tc = (cnt_q == '0);
endmodule

// File: rtl/swallow_counter.sv
module swallow_counter
    import swallow_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           upd,
    input  logic [A_W-1:0] a_val,
    input  logic [M_W-1:0] m_val,
    output logic           mc,
    output logic           fv,
    output logic           err
);
    ratio_t in_r;
    ratio_t next_r;
    ratio_t reload_r;
    logic   tc;

    assign in_r.a = a_val;
    assign in_r.m = m_val;

    swallow_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .upd    (upd),
        .in_r   (in_r),
        .next_r (next_r),
        .bad    (err)
    );

    assign reload_r = rst ? in_r : next_r;

    swallow_mcnt #(.W(M_W)) u_mcnt (
        .clk      (clk),
        .rst      (rst),
        .load_val (reload_r.m),
        .tc       (tc)
    );

    swallow_acnt #(.W(A_W)) u_acnt (
        .clk      (clk),
        .rst      (rst),
        .load     (tc),
        .load_val (reload_r.a),
        .mc       (mc)
    );

    assign fv = tc;
endmodule

// File: rtl/swallow_chk.sv
module swallow_chk
    import swallow_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           upd,
    input logic [A_W-1:0] a_val,
    input logic [M_W-1:0] m_val,
    input logic           mc,
    input logic           fv,
    input logic           err
);
    logic in_ok;
    assign in_ok = (m_val >= m_t'(M_MIN)) && (m_val > m_t'(a_val));

    // R2: with a legal pending ratio and no bypass, the feedback pulse is one period wide
    assert_fv_single_R2: assert property (@(posedge clk) disable iff (rst)
        (fv && !err && !upd) |=> !fv);

    // R3: modulus control only falls at the wrap after the feedback pulse
    assert_mc_fall_at_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(mc) |-> $past(fv));

    // R8: error output holds between strobes
    assert_err_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(err));

    // R8: a legal strobe clears the error
    assert_err_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (upd && in_ok) |=> !err);

    // R8: an illegal strobe raises the error
    assert_err_set_R8: assert property (@(posedge clk) disable iff (rst)
        (upd && !in_ok) |=> err);
endmodule

bind swallow_counter swallow_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .upd   (upd),
    .a_val (a_val),
    .m_val (m_val),
    .mc    (mc),
    .fv    (fv),
    .err   (err)
);

// File: tb/swallow_counter_tb.sv
module swallow_counter_tb;
    localparam int P     = 64;
    localparam int LIMIT = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       upd = 1'b0;
    logic [6:0] a_val = 7'd3;
    logic [9:0] m_val = 10'd10;
    logic       mc, fv, err;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    swallow_counter u_dut (
        .clk   (clk),
        .rst   (rst),
        .upd   (upd),
        .a_val (a_val),
        .m_val (m_val),
        .mc    (mc),
        .fv    (fv),
        .err   (err)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= LIMIT) begin
            errors = errors + 1;
            $display("FAIL watchdog: act %0d cycles exp fewer than %0d", cyc, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    // Advance to a negedge where fv is observed high.
    task automatic sync_fv();
        int n = 0;
        while (!fv && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Called at a negedge where fv is high; runs one full cycle.
    task automatic measure(input int strobe_at, input logic [6:0] na, input logic [9:0] nm,
                           output int len, output int low, output int tot);
        len = 0; low = 0; tot = 0;
        if (strobe_at == 0) begin
            a_val = na; m_val = nm; upd = 1'b1;
        end
        for (int k = 1; k <= 3000; k++) begin
            @(negedge clk);
            upd = 1'b0;
            len++;
            if (!mc) low++;
            tot += mc ? P : P + 1;
            if (fv) break;
            if (k == strobe_at) begin
                a_val = na; m_val = nm; upd = 1'b1;
            end
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(mc == 1'b0, "R1 mc", int'(mc), 0);
        check(fv == 1'b0, "R1 fv", int'(fv), 0);
        check(err == 1'b0, "R1 err", int'(err), 0);
    endtask

    task automatic t_ratio(input int a, input int m, input string req);
        int len, low, tot;
        sync_fv();
        measure(0, 7'(a), 10'(m), len, low, tot);
        check(len == m, {req, " R2 R7 length"}, len, m);
        check(low == a, {req, " R3 low span"}, low, a);
        check(tot == m * P + a, {req, " R4 ratio"}, tot, m * P + a);
    endtask

    task automatic t_a_zero();
        int len, low, tot;
        sync_fv();
        measure(0, 7'd0, 10'd12, len, low, tot);
        check(low == 0, "R5 mc high all cycle", low, 0);
        check(len == 12, "R5 length", len, 12);
    endtask

    task automatic t_midcycle();
        int len, low, tot;
        sync_fv();
        measure(0, 7'd5, 10'd20, len, low, tot);
        measure(3, 7'd9, 10'd30, len, low, tot);
        check(len == 20, "R6 current length kept", len, 20);
        check(low == 5, "R6 current low kept", low, 5);
        measure(-1, 7'd0, 10'd0, len, low, tot);
        check(len == 30, "R6 next length", len, 30);
        check(low == 9, "R6 next low", low, 9);
    endtask

    task automatic strobe(input int a, input int m, input int exp_err);
        @(negedge clk);
        a_val = 7'(a); m_val = 10'(m); upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        check(err == exp_err[0], "R8 err", int'(err), exp_err);
    endtask

    task automatic t_err();
        int len, low, tot;
        strobe(0, 5, 1);
        sync_fv();
        measure(-1, 7'd0, 10'd0, len, low, tot);
        check(len == 5, "R8 flagged value used", len, 5);
        strobe(20, 20, 1);
        strobe(20, 21, 0);
        strobe(0, 7, 1);
        strobe(0, 8, 0);
        repeat (4) @(negedge clk);
        check(err == 1'b0, "R8 err holds", int'(err), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_ratio(3, 10, "R3");
        t_a_zero();
        t_ratio(127, 1023, "R9");
        t_ratio(7, 8, "R9");
        t_midcycle();
        t_err();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule